// File: doc/BRIEF.md
# Hamming-protected trigger frame builder

The block turns one wide trigger word into a short burst of protected words for a serial link. When a trigger word arrives and no frame is pending, the block captures the word and the board identifier. On the next cycle it starts to offer a frame on a valid/ready stream. The frame is one header word followed by one word per payload slice, four by default. The header carries a running frame count and the board identifier.

Every 24-bit word is widened to a 30-bit codeword. Five Hamming check bits let the receiver locate and repair any single flipped bit. One overall parity bit lets it tell a double error from a single one. A trigger that arrives while a frame is still pending is discarded, and a sticky flag records the loss. The encoding itself lives in a function, so the slice width and the field widths are parameters.

Top module: `trig_frame_tx`

## Requirements
- R1: After reset, out_valid and overflow are 0. The first header sent after reset carries a frame count of 0.
- R2: When trig_valid is high in a cycle where out_valid is low, the block accepts the word. In the following cycle out_valid is 1 and out_sof is 1, which marks the header. The accepted word reaches the stream in one cycle, well inside a 15-cycle budget.
- R3: A frame is exactly N_SLICES+1 words: the header, then the payload slices from the least significant to the most significant. out_last is 1 only on the final slice, and out_valid falls in the cycle after that word is taken.
- R4: In the header's 24 data bits, bits [SEQ_W-1:0] hold the frame count. Bits [23:SEQ_W] hold the board_id sampled in the cycle of acceptance.
- R5: Codeword bits [28:0] hold Hamming positions 1..29, where bit i-1 is position i. Check bits sit at positions 1, 2, 4, 8 and 16. Data bits 0..23 fill the remaining positions in ascending order. For every check bit c, the XOR of all positions whose index has bit c set is 0. Bit 29 makes the XOR of all 30 bits equal to 0.
- R6: The frame count advances by one after each completed frame and wraps modulo 2^SEQ_W.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sof and out_last hold their values.
- R8: A trig_valid pulse while out_valid is 1 is dropped and sets overflow. The frame in flight is unchanged, and overflow stays 1 until reset.
- R9: Changes on board_id after acceptance have no effect on the header of the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger word strobe |
| trig_data | input | SLICE_W*N_SLICES | Trigger payload |
| board_id | input | ID_W | Sender identifier |
| out_valid | output | 1 | Codeword offered |
| out_ready | input | 1 | Link layer takes the codeword |
| out_data | output | SLICE_W+check+1 | Protected codeword |
| out_sof | output | 1 | Current word is the header |
| out_last | output | 1 | Current word ends the frame |
| overflow | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The bench builds the block with SEQ_W=4 and ID_W=20, keeping the 24-bit header. With these values the frame count wraps after 16 frames, so a short run reaches the wrap boundary. The wide identifier field also lets random identifiers exercise many header bits. The payload width and the 30-bit codeword keep their default sizes, so every Hamming position is exercised as it would be on the real link.

// File: rtl/trig_frame_tx.sv
module trig_frame_tx #(
  parameter int SLICE_W  = 24,
  parameter int N_SLICES = 4,
  parameter int SEQ_W    = 16,
  parameter int ID_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig_valid,
  input  logic [SLICE_W*N_SLICES-1:0]   trig_data,
  input  logic [ID_W-1:0]               board_id,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [SLICE_W+$clog2(SLICE_W+$clog2(SLICE_W)+1):0] out_data,
  output logic                          out_sof,
  output logic                          out_last,
  output logic                          overflow
);

  function automatic int chk_bits(input int d);
    int k;
    k = 1;
    while ((1 << k) < d + k + 1) k++;
    return k;
  endfunction

  localparam int PAY_W = SLICE_W * N_SLICES;
  localparam int CHK_W = chk_bits(SLICE_W);
  localparam int HAM_W = SLICE_W + CHK_W;
  localparam int CW_W  = HAM_W + 1;
  localparam int IDX_W = $clog2(N_SLICES + 1);

  function automatic logic [CW_W-1:0] encode(input logic [SLICE_W-1:0] d);
    logic [HAM_W-1:0] h;
    int j;
    h = '0;
    j = 0;
    for (int p = 1; p <= HAM_W; p++)
      if ((p & (p - 1)) != 0) begin
        h[p-1] = d[j];
        j++;
      end
    for (int c = 0; c < CHK_W; c++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p <= HAM_W; p++)
        if (((p >> c) & 1) == 1) x = x ^ h[p-1];
      h[(1 << c) - 1] = x;
    end
    return {^h, h};
  endfunction

  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [PAY_W-1:0] pay_q;
  logic [ID_W-1:0]  id_q;
  logic [SEQ_W-1:0] seq_q;
  logic             ovf_q;
  logic [SLICE_W-1:0] word;

  wire hs   = busy && out_ready;
  wire last = busy && (idx == IDX_W'(N_SLICES));

  assign word      = (idx == '0) ? SLICE_W'({id_q, seq_q}) : pay_q[SLICE_W-1:0];
  assign out_valid = busy;
  assign out_data  = encode(word);
  assign out_sof   = busy && (idx == '0);
  assign out_last  = last;
  assign overflow  = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      pay_q <= '0;
      id_q  <= '0;
      seq_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (trig_valid && busy) ovf_q <= 1'b1;
      if (trig_valid && !busy) begin
        busy  <= 1'b1;
        idx   <= '0;
        pay_q <= trig_data;
        id_q  <= board_id;
      end else if (hs) begin
        if (last) begin
          busy  <= 1'b0;
          seq_q <= seq_q + 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
          if (idx != '0) pay_q <= pay_q >> SLICE_W;
        end
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !out_valid) |=> (out_valid && out_sof));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_last)));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && out_valid) |=> overflow);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1)));

  always_comb begin
    if (rst_n && out_valid) begin
      assert_parity_R5: assert (^out_data == 1'b0);
      assert_flags_R3: assert (!(out_sof && out_last));
    end
  end

endmodule

// File: tb/sim_trig_frame_tx.sv
module sim_trig_frame_tx;
  localparam int SW = 24, NS = 4, SQ = 4, IW = 20, CW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_valid = 1'b0;
  logic [SW*NS-1:0] trig_data = '0;
  logic [IW-1:0] board_id = '0;
  logic out_valid, out_sof, out_last, overflow;
  logic out_ready = 1'b0;
  logic [CW-1:0] out_data;

  int checks = 0, failures = 0;
  logic [SQ-1:0] exp_seq = '0;
  bit exp_ovf = 1'b0;

  always #2 clk = ~clk;

  trig_frame_tx #(.SLICE_W(SW), .N_SLICES(NS), .SEQ_W(SQ), .ID_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_data(trig_data),
    .board_id(board_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_last(out_last), .overflow(overflow));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input logic [SW-1:0] exp, input bit sof, input bit lst, input string tag);
    logic [SW-1:0] got;
    logic [4:0] syn;
    int j;
    got = '0;
    j = 0;
    syn = '0;
    for (int p = 1; p <= 29; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
        got[j] = out_data[p-1];
        j++;
      end
      for (int c = 0; c < 5; c++)
        if (p[c]) syn[c] = syn[c] ^ out_data[p-1];
    end
    chk(out_valid && got == exp && out_sof == sof && out_last == lst, tag,
        {out_valid, out_sof, out_last, 37'd0, got}, {1'b1, sof, lst, 37'd0, exp});
    chk(syn == 5'd0 && (^out_data) == 1'b0, "R5 codeword parity",
        {58'd0, ^out_data, syn}, 64'd0);
  endtask

  task automatic run_frame(input logic [SW*NS-1:0] pay, input logic [IW-1:0] id, input bit inject, input bit stalls);
    logic [SW-1:0] exp;
    @(negedge clk);
    trig_valid = 1'b1;
    trig_data = pay;
    board_id = id;
    @(negedge clk);
    trig_valid = 1'b0;
    board_id = IW'($urandom);
    chk(out_valid && out_sof, "R2 accept", {62'd0, out_valid, out_sof}, 64'd3);
    for (int w = 0; w <= NS; w++) begin
      exp = (w == 0) ? {id, exp_seq} : pay[(w-1)*SW +: SW];
      if (inject && w == 2) begin
        out_ready = 1'b0;
        trig_valid = 1'b1;
        trig_data = ~pay;
        @(negedge clk);
        trig_valid = 1'b0;
        exp_ovf = 1'b1;
        chk(overflow == 1'b1, "R8 drop sets overflow", {63'd0, overflow}, 64'd1);
      end
      if (stalls) begin
        for (int s = 0; s < int'($urandom % 3); s++) begin
          out_ready = 1'b0;
          chk_word(exp, w == 0, w == NS, "R7 stall hold");
          @(negedge clk);
        end
      end
      chk_word(exp, w == 0, w == NS, (w == 0) ? "R4 R6 R9 header" : "R3 slice order");
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(!out_valid, "R3 frame end", {63'd0, out_valid}, 64'd0);
    chk(overflow == exp_ovf, "R8 overflow sticky", {63'd0, overflow}, {63'd0, exp_ovf});
    exp_seq = exp_seq + 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !overflow, "R1 reset state", {62'd0, out_valid, overflow}, 64'd0);
    run_frame('0, 20'h00000, 1'b0, 1'b0);
    run_frame('1, 20'hFFFFF, 1'b0, 1'b0);
    run_frame(96'd1, 20'h00001, 1'b0, 1'b1);
    run_frame({1'b1, 95'd0}, 20'h80000, 1'b0, 1'b1);
    for (int i = 0; i < 14; i++)
      run_frame({$urandom, $urandom, $urandom}, IW'($urandom), 1'b0, 1'b1);
    run_frame({$urandom, $urandom, $urandom}, IW'($urandom), 1'b1, 1'b1);
    for (int i = 0; i < 4; i++)
      run_frame({$urandom, $urandom, $urandom}, IW'($urandom), 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule